// File: doc/BRIEF.md
# PCI Command/Status Configuration Registers

This block keeps the 16-bit command half and the 16-bit status half of one configuration dword of a PCI function. Configuration software reaches both through a small access port: a dword-aligned byte address, a write strobe, four byte enables, write data, and read data that is valid whenever the address matches. The command half holds the enables that other logic of the function uses. These are exported as level outputs:

- memory write-and-invalidate use
- parity error response
- SERR# drive permission
- fast back-to-back to any agent

The status half has two kinds of field. Some are hardwired and report fixed capabilities. The others are sticky error flags, each set by a one-cycle event pulse from the bus interface logic. Software clears a flag only by writing a one to it. If an event arrives in the same cycle as a clear, the event wins, so no error is lost between a read and its clearing write.

Top module: `pci_cmdsts_regs`

## Requirements
- R1: After reset the command half reads 0x0000 and the status half reads 0x0280.
- R2: A read at byte address 0x04 returns the command half in bits 15:0 and the status half in bits 31:16. Any other address reads 0 and is not written.
- R3: Only command bits 4 (write-and-invalidate), 6 (parity response), 8 (SERR# drive) and 9 (back-to-back to any agent) are writable, and each drives its output. Bits 3:0, 5, 7 and 15:10 always read 0.
- R4: A write changes only the byte lanes whose enable is 1. Enable k covers data bits 8k+7 to 8k.
- R5: Status bit 7 always reads 1, bits 10:9 always read 01 and bits 6:0 always read 0, whatever is written.
- R6: Status bit 8 is set only by a parity-error event whose master flag is 1 while command bit 6 is 1.
- R7: Status bit 15 is set by an address-phase parity error, a target-write data parity error or a master-read data parity error, also while command bit 6 is 0.
- R8: Status bits 11, 12, 13 and 14 are set by the signaled-target-abort, received-target-abort, master-abort and system-error events respectively.
- R9: Writing 1 to status bit 8 or to any of bits 15:11 clears that bit. Writing 0 leaves it unchanged.
- R10: When an event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R11: The command half changes only in a cycle with an enabled write to address 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W | Configuration byte address, dword aligned |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| ev_perr | input | 1 | Parity error reported or observed on the bus |
| ev_master | input | 1 | This function was master of the transfer in ev_perr |
| ev_addr_perr | input | 1 | Address-phase parity error detected |
| ev_tgt_wr_perr | input | 1 | Data parity error as target of a write |
| ev_mst_rd_perr | input | 1 | Data parity error during a master read |
| ev_sig_tabort | input | 1 | Target abort signaled |
| ev_rcv_tabort | input | 1 | Target abort received |
| ev_mabort | input | 1 | Master abort generated |
| ev_serr | input | 1 | System error reported |
| mwi_en | output | 1 | Write-and-invalidate enable |
| perr_resp_en | output | 1 | Parity error response enable |
| serr_en | output | 1 | SERR# drive enable |
| fbb_any_en | output | 1 | Back-to-back to any agent enable |

## Verification
The assertions watch every cycle for these properties:

- The master parity flag rises only after a gated parity event.
- The detected-parity flag rises only after one of its three causes.
- A sticky flag falls only after a write of one to it.
- A master-abort event always leaves its flag set, whatever write accompanies it.
- The command half holds its value in any cycle without an enabled write.

Only the bench scenarios show the rest:

- the exact values read back
- the hardwired and reserved fields under all-ones writes
- lane-by-lane masking
- writes to a foreign address being ignored
- the outputs following the command bits

// File: rtl/pci_cs_pkg.sv
package pci_cs_pkg;
   localparam int unsigned HALF_W = 16;
   localparam int unsigned DW_W   = 32;
   localparam int unsigned LANES  = DW_W / 8;

   // command bit positions
   localparam int unsigned CMD_MWI  = 4;
   localparam int unsigned CMD_PRSP = 6;
   localparam int unsigned CMD_SERR = 8;
   localparam int unsigned CMD_FBB  = 9;

   // status bit positions
   localparam int unsigned STS_MDPE = 8;
   localparam int unsigned STS_STA  = 11;
   localparam int unsigned STS_RTA  = 12;
   localparam int unsigned STS_RMA  = 13;
   localparam int unsigned STS_SSE  = 14;
   localparam int unsigned STS_DPE  = 15;

   localparam logic [HALF_W-1:0] STS_W1C_MASK = 16'hF900;
   localparam logic [HALF_W-1:0] STS_FIXED_MASK = 16'h06FF;

   typedef struct packed {
      logic perr;
      logic master;
      logic addr_perr;
      logic tgt_wr_perr;
      logic mst_rd_perr;
      logic sig_tabort;
      logic rcv_tabort;
      logic mabort;
      logic serr;
   } err_ev_t;
endpackage

// File: rtl/pci_cs_decode.sv
module pci_cs_decode
   import pci_cs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h04
) (
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic               cfg_wr,
   input  logic [LANES-1:0]   cfg_be,
   input  logic [DW_W-1:0]    cfg_wdata,
   input  logic [HALF_W-1:0]  cmd_val,
   input  logic [HALF_W-1:0]  sts_val,
   output logic [HALF_W-1:0]  cmd_wmask,
   output logic [HALF_W-1:0]  sts_clr,
   output logic               cmd_wr_any,
   output logic [DW_W-1:0]    cfg_rdata
);
   localparam int unsigned HLANES = HALF_W / 8;

   logic               hit;
   logic [LANES-1:0]   lane_we;
   logic [DW_W-1:0]    bit_we;

   generate
      if (REG_ADDR[1:0] != 2'b00) begin : g_bad_addr
         $error("REG_ADDR must be dword aligned");
      end
   endgenerate

   assign hit     = (cfg_addr == REG_ADDR);
   assign lane_we = (cfg_wr && hit) ? cfg_be : '0;

   // expand each lane enable to its eight data bits
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign bit_we[l*8 +: 8] = {8{lane_we[l]}};
   end

   assign cmd_wmask  = bit_we[HALF_W-1:0];
   assign sts_clr    = bit_we[DW_W-1:HALF_W] & cfg_wdata[DW_W-1:HALF_W];
   assign cmd_wr_any = |lane_we[HLANES-1:0];
   assign cfg_rdata  = hit ? {sts_val, cmd_val} : '0;
endmodule

// File: rtl/pci_cs_cmd_reg.sv
module pci_cs_cmd_reg
   import pci_cs_pkg::*;
#(
   parameter logic [HALF_W-1:0] RW_MASK = 16'h0350
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] wmask,
   input  logic [HALF_W-1:0] wdata,
   input  logic              wr_any,
   output logic [HALF_W-1:0] cmd_q
);
   logic [HALF_W-1:0] cmd_d;

   generate
      if ((RW_MASK & 16'hFCA0) != '0) begin : g_bad_mask
         $error("RW_MASK touches a reserved or hardwired command bit");
      end
   endgenerate

   assign cmd_d = ((cmd_q & ~wmask) | (wdata & wmask)) & RW_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_q <= '0;
      else        cmd_q <= cmd_d;
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_any |=> $stable(cmd_q)); // R11
endmodule

// File: rtl/pci_cs_sts_reg.sv
module pci_cs_sts_reg
   import pci_cs_pkg::*;
#(
   parameter bit FBB_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  err_ev_t           ev,
   input  logic              perr_resp_en,
   input  logic [HALF_W-1:0] clr,
   output logic [HALF_W-1:0] sts_val
);
   localparam logic [HALF_W-1:0] FIXED_VAL =
      16'h0200 | (FBB_CAPABLE ? 16'h0080 : 16'h0000);

   logic [HALF_W-1:0] set_v;
   logic [HALF_W-1:0] flags_q, flags_d;

   generate
      if ((FIXED_VAL & ~STS_FIXED_MASK) != '0) begin : g_bad_fixed
         $error("fixed status value overlaps a sticky flag");
      end
   endgenerate

   always_comb begin
      set_v           = '0;
      set_v[STS_MDPE] = ev.perr && ev.master && perr_resp_en;
      set_v[STS_STA]  = ev.sig_tabort;
      set_v[STS_RTA]  = ev.rcv_tabort;
      set_v[STS_RMA]  = ev.mabort;
      set_v[STS_SSE]  = ev.serr;
      set_v[STS_DPE]  = ev.addr_perr || ev.tgt_wr_perr || ev.mst_rd_perr;
   end

   // set has priority over a simultaneous clear
   assign flags_d = ((flags_q & ~clr) | set_v) & STS_W1C_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign sts_val = flags_q | FIXED_VAL;

   AST_MDPE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[STS_MDPE]) |-> $past(ev.perr && ev.master && perr_resp_en)); // R6
   AST_DPE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[STS_DPE]) |-> $past(ev.addr_perr || ev.tgt_wr_perr || ev.mst_rd_perr)); // R7
   AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((~flags_q & $past(flags_q) & ~$past(clr)) == '0)); // R9
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ev.mabort |=> flags_q[STS_RMA]); // R10
endmodule

// File: rtl/pci_cmdsts_regs.sv
module pci_cmdsts_regs
   import pci_cs_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h04,
   parameter logic [15:0] CMD_RW_MASK = 16'h0350,
   parameter bit FBB_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              ev_perr,
   input  logic              ev_master,
   input  logic              ev_addr_perr,
   input  logic              ev_tgt_wr_perr,
   input  logic              ev_mst_rd_perr,
   input  logic              ev_sig_tabort,
   input  logic              ev_rcv_tabort,
   input  logic              ev_mabort,
   input  logic              ev_serr,
   output logic              mwi_en,
   output logic              perr_resp_en,
   output logic              serr_en,
   output logic              fbb_any_en
);
   generate
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W too small to reach the register dword");
      end
   endgenerate

   err_ev_t           ev;
   logic [HALF_W-1:0] cmd_q, sts_val, cmd_wmask, sts_clr;
   logic              cmd_wr_any;

   assign ev = '{perr: ev_perr, master: ev_master, addr_perr: ev_addr_perr,
                 tgt_wr_perr: ev_tgt_wr_perr, mst_rd_perr: ev_mst_rd_perr,
                 sig_tabort: ev_sig_tabort, rcv_tabort: ev_rcv_tabort,
                 mabort: ev_mabort, serr: ev_serr};

   pci_cs_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dec_i (
      .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cmd_val(cmd_q), .sts_val(sts_val),
      .cmd_wmask(cmd_wmask), .sts_clr(sts_clr), .cmd_wr_any(cmd_wr_any),
      .cfg_rdata(cfg_rdata));

   pci_cs_cmd_reg #(.RW_MASK(CMD_RW_MASK)) cmd_i (
      .clk(clk), .rst_n(rst_n), .wmask(cmd_wmask),
      .wdata(cfg_wdata[HALF_W-1:0]), .wr_any(cmd_wr_any), .cmd_q(cmd_q));

   pci_cs_sts_reg #(.FBB_CAPABLE(FBB_CAPABLE)) sts_i (
      .clk(clk), .rst_n(rst_n), .ev(ev), .perr_resp_en(perr_resp_en),
      .clr(sts_clr), .sts_val(sts_val));

   assign mwi_en       = cmd_q[CMD_MWI];
   assign perr_resp_en = cmd_q[CMD_PRSP];
   assign serr_en      = cmd_q[CMD_SERR];
   assign fbb_any_en   = cmd_q[CMD_FBB];
endmodule

// File: tb/pci_cmdsts_regs_tb.sv
module pci_cmdsts_regs_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] RA = 8'h04;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_addr = RA;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   // [0]perr [1]master [2]addr_perr [3]tgt_wr_perr [4]mst_rd_perr
   // [5]sig_tabort [6]rcv_tabort [7]mabort [8]serr
   logic [8:0]  evb = '0;
   logic        mwi_en, perr_resp_en, serr_en, fbb_any_en;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pci_cmdsts_regs dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .ev_perr(evb[0]), .ev_master(evb[1]), .ev_addr_perr(evb[2]),
      .ev_tgt_wr_perr(evb[3]), .ev_mst_rd_perr(evb[4]), .ev_sig_tabort(evb[5]),
      .ev_rcv_tabort(evb[6]), .ev_mabort(evb[7]), .ev_serr(evb[8]),
      .mwi_en(mwi_en), .perr_resp_en(perr_resp_en), .serr_en(serr_en),
      .fbb_any_en(fbb_any_en));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; cfg_addr = RA;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      cfg_addr = a; #1; d = cfg_rdata; cfg_addr = RA;
   endtask

   task automatic pulse(logic [8:0] m);
      @(negedge clk); evb = m;
      @(negedge clk); evb = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(RA, d);      chk("R1 R2 reset dword", d, 32'h0280_0000);
      rd(8'h08, d);   chk("R2 foreign address", d, 32'h0);
      chk("R1 outputs", {mwi_en, perr_resp_en, serr_en, fbb_any_en}, 0);
   endtask

   task automatic t_cmd();
      logic [31:0] d;
      wr(RA, 4'b0011, 32'h0000_FFFF);
      rd(RA, d); chk("R3 writable command bits", d, 32'h0280_0350);
      chk("R3 outputs", {mwi_en, perr_resp_en, serr_en, fbb_any_en}, 4'hF);
      wr(RA, 4'b1111, 32'hFFFF_FFFF);
      rd(RA, d); chk("R5 hardwired status under ones", d, 32'h0280_0350);
   endtask

   task automatic t_lanes();
      logic [31:0] d;
      wr(RA, 4'b0001, 32'h0);
      rd(RA, d); chk("R4 low lane only", d, 32'h0280_0300);
      chk("R4 outputs", {mwi_en, perr_resp_en, serr_en, fbb_any_en}, 4'b0011);
      wr(RA, 4'b0010, 32'h0);
      rd(RA, d); chk("R4 high lane", d, 32'h0280_0000);
      wr(8'h08, 4'b1111, 32'hFFFF_FFFF);
      rd(RA, d); chk("R11 R2 foreign write ignored", d, 32'h0280_0000);
   endtask

   task automatic t_mdpe();
      logic [31:0] d;
      pulse(9'b000000011);
      rd(RA, d); chk("R6 gated off by response bit", d, 32'h0280_0000);
      wr(RA, 4'b0001, 32'h0000_0040);
      pulse(9'b000000001);
      rd(RA, d); chk("R6 needs master", d, 32'h0280_0040);
      pulse(9'b000000011);
      rd(RA, d); chk("R6 set", d, 32'h0380_0040);
      wr(RA, 4'b1000, 32'h0100_0000);
      rd(RA, d); chk("R9 clear bit 8", d, 32'h0280_0040);
   endtask

   task automatic t_dpe();
      logic [31:0] d;
      wr(RA, 4'b0011, 32'h0);
      for (int k = 2; k <= 4; k++) begin
         pulse(9'(1 << k));
         rd(RA, d); chk("R7 detected parity", d, 32'h8280_0000);
         wr(RA, 4'b1000, 32'h8000_0000);
         rd(RA, d); chk("R9 clear bit 15", d, 32'h0280_0000);
      end
   endtask

   task automatic t_aborts();
      logic [31:0] d;
      pulse(9'b000100000); pulse(9'b001000000);
      pulse(9'b010000000); pulse(9'b100000000);
      rd(RA, d); chk("R8 abort and error flags", d, 32'h7A80_0000);
      wr(RA, 4'b1100, 32'h0);
      rd(RA, d); chk("R9 zero write keeps flags", d, 32'h7A80_0000);
      wr(RA, 4'b1000, 32'h1000_0000);
      rd(RA, d); chk("R9 single clear", d, 32'h6A80_0000);
      wr(RA, 4'b1100, 32'hFFFF_0000);
      rd(RA, d); chk("R9 clear all", d, 32'h0280_0000);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      @(negedge clk);
      evb = 9'b010000000;
      cfg_addr = RA; cfg_be = 4'b1000; cfg_wdata = 32'h2000_0000; cfg_wr = 1'b1;
      @(negedge clk);
      evb = '0; cfg_wr = 1'b0; cfg_be = '0;
      rd(RA, d); chk("R10 set wins over clear", d, 32'h2280_0000);
      wr(RA, 4'b1000, 32'h2000_0000);
      rd(RA, d); chk("R9 later clear", d, 32'h0280_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd();
      t_lanes();
      t_mdpe();
      t_dpe();
      t_aborts();
      t_collide();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule